// File: doc/BRIEF.md
# Write-Busy Status Read Path

This block is the read-data selector between the storage array of a self-timed nonvolatile memory and its data bus. Outside a programming cycle a read returns the array byte. While the internal programming cycle runs, every read returns a status byte instead. Bit 7 carries the inverse of bit 7 of the byte most recently written. Bit 6 changes value from one read access to the next. All other bits are zero. A host can therefore detect the end of programming by polling the bus, and no separate ready pin is needed.

A read access is the span of cycles in which both the select strobe and the read strobe are active. The start of an access is detected as the first cycle of that span. The toggle state advances once per access that starts while programming is running, however long the access lasts. The data and drive outputs are registered. Both reflect the strobes, busy flag and array data sampled at the previous clock edge.

Top module: `wbusy_rdpath`

## Requirements
- R1: `drive_o` is 1 in the cycle after a clock edge at which both strobes were active, and 0 after an edge at which either strobe was inactive (default active-high strobes).
- R2: After an edge with an active read and `busy_i` = 0, `data_o` equals the `array_i` value sampled at that edge.
- R3: After an edge with an active read and `busy_i` = 1, `data_o[7]` equals the inverse of `last_msb_i` sampled at that edge.
- R4: After an edge with an active read and `busy_i` = 1, `data_o[5:0]` (and any bit above 7) is 0, whatever `array_i` holds.
- R5: During busy, `data_o[6]` holds one value for all cycles of a single read access, and takes the opposite value in the next read access that starts while busy.
- R6: The toggle state does not advance on idle cycles or on read accesses that start while `busy_i` = 0. Across such gaps, consecutive busy accesses still differ in bit 6 by exactly one step.
- R7: At the first edge of an ongoing access where `busy_i` is 0, the next output is the full array byte, with no status substitution.
- R8: While `drive_o` is 0, `data_o` is all zeros.
- R9: After reset, `drive_o` is 0 and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Device select strobe (active level set by STROBE_LOW) |
| rd_i | input | 1 | Read strobe (active level set by STROBE_LOW) |
| busy_i | input | 1 | Internal programming cycle in progress |
| last_msb_i | input | 1 | Bit 7 of the last byte written |
| array_i | input | DATA_W | Byte read from the storage array |
| data_o | output | DATA_W | Registered read data toward the bus |
| drive_o | output | 1 | Registered bus drive enable; 0 means high impedance |

## Verification
The bench targets the toggle bit. It holds a single access for several cycles, which a design advancing per cycle instead of per access would fail by changing bit 6 mid-access. It also places idle cycles and non-busy reads between busy accesses, which a free-running toggle would fail by skipping or repeating a value. It drops busy in the middle of an access. A design that kept status substitution until the next access would then return stale status instead of array data. It also covers gating with only one strobe active, and polling with both values of the last written bit 7, while the array holds all ones. A design that leaked array bits into the reserved field, or did not invert bit 7, would show the wrong byte.

// File: rtl/wbrd_pkg.sv
package wbrd_pkg;
   localparam int POLL_POS   = 7;
   localparam int TOGGLE_POS = 6;
   localparam int MIN_W      = 8;
endpackage

// File: rtl/wbrd_edge.sv
module wbrd_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic level_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_i;
   end
   assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/wbrd_toggle.sv
module wbrd_toggle #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance_i,
   output logic bit_o
);
   logic state_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         state_q <= INIT;
      else if (advance_i) state_q <= ~state_q;
   end
   // value presented for the access being sampled now
   assign bit_o = advance_i ? ~state_q : state_q;
endmodule

// File: rtl/wbrd_mux.sv
module wbrd_mux
   import wbrd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              rd_i,
   input  logic              busy_i,
   input  logic              last_msb_i,
   input  logic              tog_i,
   input  logic [DATA_W-1:0] array_i,
   output logic [DATA_W-1:0] next_o
);
   always_comb begin
      next_o = '0;
      if (rd_i) begin
         if (busy_i) begin
            next_o[POLL_POS]   = ~last_msb_i;
            next_o[TOGGLE_POS] = tog_i;
         end else begin
            next_o = array_i;
         end
      end
   end
endmodule

// File: rtl/wbusy_rdpath.sv
module wbusy_rdpath
   import wbrd_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit STROBE_LOW = 1'b0,
   parameter bit TOG_INIT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              rd_i,
   input  logic              busy_i,
   input  logic              last_msb_i,
   input  logic [DATA_W-1:0] array_i,
   output logic [DATA_W-1:0] data_o,
   output logic              drive_o
);
   generate
      if (DATA_W < MIN_W) begin : g_bad_width
         $error("wbusy_rdpath: DATA_W must be at least 8");
      end
   endgenerate

   logic rd_act;
   generate
      if (STROBE_LOW) begin : g_low
         assign rd_act = ~sel_i & ~rd_i;
      end else begin : g_high
         assign rd_act = sel_i & rd_i;
      end
   endgenerate

   logic rd_rise, tog;
   logic [DATA_W-1:0] nxt;

   wbrd_edge u_edge (
      .clk(clk), .rst_n(rst_n), .level_i(rd_act), .rise_o(rd_rise)
   );

   wbrd_toggle #(.INIT(TOG_INIT)) u_tog (
      .clk(clk), .rst_n(rst_n), .advance_i(rd_rise & busy_i), .bit_o(tog)
   );

   wbrd_mux #(.DATA_W(DATA_W)) u_mux (
      .rd_i(rd_act), .busy_i(busy_i), .last_msb_i(last_msb_i),
      .tog_i(tog), .array_i(array_i), .next_o(nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         drive_o <= 1'b0;
      end else begin
         data_o  <= nxt;
         drive_o <= rd_act;
      end
   end
endmodule

// File: rtl/wbrd_chk.sv
module wbrd_chk #(
   parameter int DATA_W     = 8,
   parameter bit STROBE_LOW = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_i,
   input logic              rd_i,
   input logic              busy_i,
   input logic              last_msb_i,
   input logic [DATA_W-1:0] array_i,
   input logic [DATA_W-1:0] data_o,
   input logic              drive_o
);
   logic rd, rdb_prev;
   assign rd = STROBE_LOW ? (!sel_i && !rd_i) : (sel_i && rd_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdb_prev <= 1'b0;
      else        rdb_prev <= rd && busy_i;
   end

   a_r1_drive: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> drive_o);
   a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !drive_o);
   a_r2_array: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !busy_i) |=> data_o == $past(array_i));
   a_r3_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && busy_i) |=> data_o[7] == !$past(last_msb_i));
   a_r4_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && busy_i) |=> data_o[5:0] == 6'd0);
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && busy_i && rdb_prev) |=> data_o[6] == $past(data_o[6]));
   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_o |-> data_o == '0);
endmodule

bind wbusy_rdpath wbrd_chk #(.DATA_W(DATA_W), .STROBE_LOW(STROBE_LOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rd_i(rd_i), .busy_i(busy_i),
   .last_msb_i(last_msb_i), .array_i(array_i), .data_o(data_o), .drive_o(drive_o)
);

// File: tb/sim_wbusy_rdpath.sv
`timescale 1ns/1ps
module sim_wbusy_rdpath;
   logic clk = 1'b0, rst_n = 1'b0;
   logic sel = 1'b0, rd = 1'b0, busy = 1'b0, lmsb = 1'b0;
   logic [7:0] arr = 8'h00;
   logic [7:0] dout;
   logic       drv;
   int nchk = 0, nfail = 0;
   logic tprev;
   bit   done = 0;

   always #5 clk = ~clk;

   wbusy_rdpath u0 (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .rd_i(rd), .busy_i(busy),
      .last_msb_i(lmsb), .array_i(arr), .data_o(dout), .drive_o(drv)
   );

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive inputs at negedge, then wait one edge and return at the next negedge
   task automatic step(input logic s, input logic r, input logic b, input logic m, input logic [7:0] a);
      sel = s; rd = r; busy = b; lmsb = m; arr = a;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R9 drive", {8'h00, drv}, 9'h000);
      chk("R9 data", {1'b0, dout}, 9'h000);
   endtask

   task automatic t_gating;
      step(1, 0, 0, 0, 8'hA5);
      chk("R1 sel only", {8'h00, drv}, 9'h000);
      chk("R8 sel only", {1'b0, dout}, 9'h000);
      step(0, 1, 0, 0, 8'hA5);
      chk("R1 rd only", {8'h00, drv}, 9'h000);
      chk("R8 rd only", {1'b0, dout}, 9'h000);
      step(0, 0, 0, 0, 8'h00);
   endtask

   task automatic t_normal;
      step(1, 1, 0, 0, 8'hA5);
      chk("R1 drive on", {8'h00, drv}, 9'h001);
      chk("R2 data A5", {1'b0, dout}, 9'h0A5);
      step(1, 1, 0, 1, 8'h3C);
      chk("R2 data 3C", {1'b0, dout}, 9'h03C);
      step(0, 0, 0, 0, 8'h00);
      chk("R1 drive off", {8'h00, drv}, 9'h000);
   endtask

   task automatic t_poll;
      step(1, 1, 1, 1, 8'hFF);
      chk("R3 msb1", {1'b0, dout[7]}, 9'h000);
      chk("R4 low zero", {3'b0, dout[5:0]}, 9'h000);
      step(0, 0, 1, 1, 8'hFF);
      step(1, 1, 1, 0, 8'hFF);
      chk("R3 msb0", {1'b0, dout[7]}, 9'h001);
      chk("R4 low zero 2", {3'b0, dout[5:0]}, 9'h000);
      tprev = dout[6];
      step(0, 0, 1, 0, 8'hFF);
   endtask

   task automatic t_toggle;
      for (int k = 0; k < 3; k++) begin
         step(1, 1, 1, 0, 8'h00);
         chk("R5 flips per access", {1'b0, dout[6]}, {8'h00, ~tprev});
         tprev = dout[6];
         for (int c = 0; c < 2; c++) begin
            step(1, 1, 1, 0, 8'h00);
            chk("R5 stable in access", {1'b0, dout[6]}, {8'h00, tprev});
         end
         step(0, 0, 1, 0, 8'h00);
      end
   endtask

   task automatic t_pause;
      step(0, 0, 1, 0, 8'h00);
      step(0, 0, 1, 0, 8'h00);
      step(1, 1, 0, 0, 8'h5A);
      chk("R6 nonbusy read data", {1'b0, dout}, 9'h05A);
      step(0, 0, 0, 0, 8'h00);
      step(1, 1, 0, 0, 8'hC3);
      step(0, 0, 1, 0, 8'h00);
      step(1, 1, 1, 0, 8'h00);
      chk("R6 single step after gap", {1'b0, dout[6]}, {8'h00, ~tprev});
      tprev = dout[6];
      step(0, 0, 1, 0, 8'h00);
   endtask

   task automatic t_release;
      step(1, 1, 1, 1, 8'h96);
      chk("R7 status before drop", {1'b0, dout[7]}, 9'h000);
      tprev = dout[6];
      step(1, 1, 0, 1, 8'h96);
      chk("R7 array on drop", {1'b0, dout}, 9'h096);
      step(1, 1, 0, 1, 8'h69);
      chk("R7 array continues", {1'b0, dout}, 9'h069);
      step(0, 0, 0, 0, 8'h00);
      chk("R8 quiet after", {1'b0, dout}, 9'h000);
      step(0, 0, 1, 0, 8'h00);
      step(1, 1, 1, 0, 8'h00);
      chk("R5 after release", {1'b0, dout[6]}, {8'h00, ~tprev});
      step(0, 0, 0, 0, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gating();
      t_normal();
      t_poll();
      t_toggle();
      t_pause();
      t_release();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule